// File: doc/BRIEF.md
# Line Buffer Partition Configuration Selector

This block picks how the vertical-scaler line buffer is split between luma, chroma and alpha storage. A single `start` pulse loads a line description: the luma and chroma viewport widths, the output rectangle width, a code for the pixel depth stored in the buffer, the alpha enable, the 4:2:0 flag, the vertical tap counts and the rounded-up vertical scale ratios for both planes. The block then works through the candidate memory configurations in a fixed priority order. For each one it computes how many whole lines (partitions) fit in each plane's storage and tests whether those counts can serve the requested taps. It reports the first configuration that passes, with its two partition counts.

Every division is done by one shared iterative divider, one quotient bit per clock. The latency therefore depends only on how many configurations are evaluated. The interface is plain control and status: there is no streaming data and no back-pressure. A start pulse is taken only while `busy` is low. The result is presented with a one-cycle `done` pulse and is held until the next `done`.

Top module: `lb_cfg_search`

## Requirements
- R1: The luma line size is min(luma viewport width, output width) and the chroma line size is min(chroma viewport width, output width); a line size of 0 is treated as 1. The depth code maps to bits per component as follows: 0 gives 10, 1 gives 8, 2 gives 6 and 3 gives 12. Words per line are ceil(line*bpc/72) for luma and chroma, and ceil(luma line/6) for alpha.
- R2: Storage in words (luma, chroma, alpha) for each configuration: 1 = (816, 816, 984), 2 = (1088, 1088, 1312), 3 = (4448, 1904, 2752), 0 = (2752, 2752, 2752). `cfg_sel` carries the configuration number as a 2-bit binary value.
- R3: A plane's partition count is floor(storage / words per line). With alpha enabled, the luma count is reduced to the alpha count when that is smaller. Both reported counts are capped at 64.
- R4: A plane passes when vtaps <= partitions - ratio_ceil + 2 if ratio_ceil > 2, and when vtaps <= partitions otherwise. A configuration is accepted only when both planes pass.
- R5: Configurations are evaluated in the order 1, 2, 3, 0. Configuration 3 is skipped unless `fmt_420` is high. The first accepted configuration is reported; configuration 0 is always reported if it is reached.
- R6: With `force_max` high at the accepted start, only configuration 0 is evaluated, and its counts are reported.
- R7: `err` is high at `done` exactly when the reported configuration is 0 and it fails the R4 check.
- R8: With k configurations evaluated, `done` is high for one cycle, exactly 55*(k+1) cycles after the cycle in which start was accepted (with the default 16-bit divider).
- R9: `busy` is high from the cycle after an accepted start until the cycle before `done`. A start pulse while `busy` is high has no effect. Outputs are 0 after reset and change only when `done` is high. A start in the `done` cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, sampled while idle |
| force_max | input | 1 | Evaluate configuration 0 only |
| luma_vp_w | input | 12 | Luma viewport width |
| chroma_vp_w | input | 12 | Chroma viewport width |
| out_w | input | 12 | Output rectangle width |
| depth_code | input | 2 | Buffer pixel depth code |
| alpha_en | input | 1 | Alpha plane stored |
| fmt_420 | input | 1 | Source is 4:2:0 |
| vtaps_y | input | 4 | Luma vertical taps |
| vtaps_c | input | 4 | Chroma vertical taps |
| vratio_ceil_y | input | 4 | Ceiling of luma vertical ratio |
| vratio_ceil_c | input | 4 | Ceiling of chroma vertical ratio |
| busy | output | 1 | Search in progress |
| done | output | 1 | Result valid pulse |
| cfg_sel | output | 2 | Selected configuration |
| parts_y | output | 7 | Luma partitions of selection |
| parts_c | output | 7 | Chroma partitions of selection |
| err | output | 1 | Fallback also failed the tap check |

## Verification
The assertions check the cycle-level rules on every cycle. These cover the one-cycle `done` pulse and its position after a busy period, the acceptance of start only while idle, outputs that hold between results, the 64 cap on both counts, and `err` appearing only with configuration 0. The bench's scenarios cover what depends on arithmetic and search. These include the chosen configuration and counts for narrow, wide, 4:2:0, alpha-limited, high-ratio, zero-width and impossible requests, as well as the forced path. The scenarios also show that the exact latency grows with the number of configurations tried, and that a start pulse during a search leaves the result unchanged.

// File: rtl/lb_cfg_pkg.sv
package lb_cfg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_CHK  = 2'd2
  } srch_state_t;

  // depth code -> bits per component
  function automatic logic [3:0] bpc_of(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd10;
      2'd1:    return 4'd8;
      2'd2:    return 4'd6;
      default: return 4'd12;
    endcase
  endfunction

endpackage

// File: rtl/lb_cfg_div.sv
module lb_cfg_div #(
  parameter int NW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [NW-1:0] dividend,
  input  logic [NW-1:0] divisor,
  output logic          fin,
  output logic [NW-1:0] quot
);
  localparam int CW = $clog2(NW + 1);

  logic [NW-1:0] rem_q, quo_q, dsr_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, fin_q;
  logic [NW:0]   shifted;
  logic [NW-1:0] diff;
  logic          fits;

  assign shifted = {rem_q, quo_q[NW-1]};
  assign fits    = shifted >= {1'b0, dsr_q};
  assign diff    = shifted[NW-1:0] - dsr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dsr_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (!run_q) begin
        if (go) begin
          rem_q <= '0;
          quo_q <= dividend;
          dsr_q <= divisor;
          cnt_q <= CW'(NW);
          run_q <= 1'b1;
        end
      end else begin
        rem_q <= fits ? diff : shifted[NW-1:0];
        quo_q <= {quo_q[NW-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q <= 1'b0;
          fin_q <= 1'b1;
        end
      end
    end
  end

  assign fin  = fin_q;
  assign quot = quo_q;
endmodule

// File: rtl/lb_cfg_rom.sv
module lb_cfg_rom #(
  parameter int NW      = 16,
  parameter int BANK_A  = 816,
  parameter int BANK_B  = 1088,
  parameter int BANK_C  = 848,
  parameter int ALPHA_A = 984,
  parameter int ALPHA_B = 1312,
  parameter int ALPHA_C = 456
) (
  input  logic [1:0]    cfg,
  output logic [NW-1:0] mem_y,
  output logic [NW-1:0] mem_c,
  output logic [NW-1:0] mem_a
);
  localparam int AB      = BANK_A + BANK_B;
  localparam int FULL    = AB + BANK_C;
  localparam int WIDE_Y  = AB + 3 * BANK_C;
  localparam int ALL_A   = ALPHA_A + ALPHA_B + ALPHA_C;

  always_comb begin
    case (cfg)
      2'd1: begin mem_y = NW'(BANK_A); mem_c = NW'(BANK_A); mem_a = NW'(ALPHA_A); end
      2'd2: begin mem_y = NW'(BANK_B); mem_c = NW'(BANK_B); mem_a = NW'(ALPHA_B); end
      2'd3: begin mem_y = NW'(WIDE_Y); mem_c = NW'(AB);     mem_a = NW'(ALL_A);   end
      default: begin mem_y = NW'(FULL); mem_c = NW'(FULL); mem_a = NW'(ALL_A);  end
    endcase
  end
endmodule

// File: rtl/lb_cfg_fit.sv
module lb_cfg_fit #(
  parameter int NW       = 16,
  parameter int TAP_W    = 4,
  parameter int RAT_W    = 4,
  parameter int PART_MAX = 64,
  parameter int PART_W   = $clog2(PART_MAX + 1)
) (
  input  logic [1:0][NW-1:0]    q_pl,
  input  logic [NW-1:0]         q_alpha,
  input  logic                  alpha_en,
  input  logic [1:0][TAP_W-1:0] vt_pl,
  input  logic [1:0][RAT_W-1:0] cr_pl,
  output logic [1:0][PART_W-1:0] part_pl,
  output logic                  fits
);
  localparam int SW = PART_W + RAT_W + TAP_W + 2;

  logic [1:0] ok_pl;

  for (genvar g = 0; g < 2; g++) begin : g_plane
    logic [NW-1:0] lim;
    logic [SW-1:0] need, have;
    always_comb begin
      lim = q_pl[g];
      if (g == 0 && alpha_en && q_alpha < lim) lim = q_alpha;
      part_pl[g] = (lim > NW'(PART_MAX)) ? PART_W'(PART_MAX) : lim[PART_W-1:0];
      if (cr_pl[g] > RAT_W'(2)) begin
        need = SW'(vt_pl[g]) + SW'(cr_pl[g]);
        have = SW'(part_pl[g]) + SW'(2);
      end else begin
        need = SW'(vt_pl[g]);
        have = SW'(part_pl[g]);
      end
      ok_pl[g] = need <= have;
    end
  end

  assign fits = &ok_pl;
endmodule

// File: rtl/lb_cfg_search.sv
module lb_cfg_search #(
  parameter int W        = 12,
  parameter int TAP_W    = 4,
  parameter int RAT_W    = 4,
  parameter int NW       = 16,
  parameter int PART_MAX = 64,
  parameter int PART_W   = $clog2(PART_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              force_max,
  input  logic [W-1:0]      luma_vp_w,
  input  logic [W-1:0]      chroma_vp_w,
  input  logic [W-1:0]      out_w,
  input  logic [1:0]        depth_code,
  input  logic              alpha_en,
  input  logic              fmt_420,
  input  logic [TAP_W-1:0]  vtaps_y,
  input  logic [TAP_W-1:0]  vtaps_c,
  input  logic [RAT_W-1:0]  vratio_ceil_y,
  input  logic [RAT_W-1:0]  vratio_ceil_c,
  output logic              busy,
  output logic              done,
  output logic [1:0]        cfg_sel,
  output logic [PART_W-1:0] parts_y,
  output logic [PART_W-1:0] parts_c,
  output logic              err
);
  import lb_cfg_pkg::*;

  localparam int LAST_OP = 5;

  srch_state_t state_q;
  logic [2:0]  op_q;
  logic        pend_q;
  logic [1:0]  cfg_q;

  logic [W-1:0]     ly_q, lc_q;
  logic [3:0]       bpc_q;
  logic             alpha_q, f420_q;
  logic [TAP_W-1:0] vty_q, vtc_q;
  logic [RAT_W-1:0] cry_q, crc_q;
  logic [NW-1:0]    wy_q, wc_q, wa_q, qy_q, qc_q, qa_q;

  logic [W-1:0]  ly_raw, lc_raw, ly_in, lc_in;
  logic          go, fin;
  logic [NW-1:0] dvd, dsr, quot;
  logic [NW-1:0] mem_y, mem_c, mem_a;
  logic [1:0][PART_W-1:0] part_pl;
  logic          fits;
  logic [1:0]    cfg_next;

  // line sizes at capture
  assign ly_raw = (luma_vp_w < out_w) ? luma_vp_w : out_w;
  assign lc_raw = (chroma_vp_w < out_w) ? chroma_vp_w : out_w;
  assign ly_in  = (ly_raw == '0) ? W'(1) : ly_raw;
  assign lc_in  = (lc_raw == '0) ? W'(1) : lc_raw;

  lb_cfg_rom #(.NW(NW)) u_rom (
    .cfg(cfg_q), .mem_y(mem_y), .mem_c(mem_c), .mem_a(mem_a)
  );

  // operand selection for the shared divider
  always_comb begin
    case (op_q)
      3'd0:    begin dvd = NW'(ly_q) * NW'(bpc_q) + NW'(71); dsr = NW'(72); end
      3'd1:    begin dvd = NW'(lc_q) * NW'(bpc_q) + NW'(71); dsr = NW'(72); end
      3'd2:    begin dvd = NW'(ly_q) + NW'(5);               dsr = NW'(6);  end
      3'd3:    begin dvd = mem_y; dsr = wy_q; end
      3'd4:    begin dvd = mem_c; dsr = wc_q; end
      default: begin dvd = mem_a; dsr = wa_q; end
    endcase
  end

  assign go = (state_q == ST_RUN) && !pend_q;

  lb_cfg_div #(.NW(NW)) u_div (
    .clk(clk), .rst_n(rst_n), .go(go), .dividend(dvd), .divisor(dsr),
    .fin(fin), .quot(quot)
  );

  lb_cfg_fit #(
    .NW(NW), .TAP_W(TAP_W), .RAT_W(RAT_W), .PART_MAX(PART_MAX), .PART_W(PART_W)
  ) u_fit (
    .q_pl({qc_q, qy_q}), .q_alpha(qa_q), .alpha_en(alpha_q),
    .vt_pl({vtc_q, vty_q}), .cr_pl({crc_q, cry_q}),
    .part_pl(part_pl), .fits(fits)
  );

  // priority order 1 -> 2 -> (3 if 4:2:0) -> 0
  always_comb begin
    case (cfg_q)
      2'd1:    cfg_next = 2'd2;
      2'd2:    cfg_next = f420_q ? 2'd3 : 2'd0;
      default: cfg_next = 2'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      pend_q  <= 1'b0;
      cfg_q   <= '0;
      ly_q    <= '0;
      lc_q    <= '0;
      bpc_q   <= '0;
      alpha_q <= 1'b0;
      f420_q  <= 1'b0;
      vty_q   <= '0;
      vtc_q   <= '0;
      cry_q   <= '0;
      crc_q   <= '0;
      wy_q    <= '0;
      wc_q    <= '0;
      wa_q    <= '0;
      qy_q    <= '0;
      qc_q    <= '0;
      qa_q    <= '0;
      done    <= 1'b0;
      cfg_sel <= '0;
      parts_y <= '0;
      parts_c <= '0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            ly_q    <= ly_in;
            lc_q    <= lc_in;
            bpc_q   <= bpc_of(depth_code);
            alpha_q <= alpha_en;
            f420_q  <= fmt_420;
            vty_q   <= vtaps_y;
            vtc_q   <= vtaps_c;
            cry_q   <= vratio_ceil_y;
            crc_q   <= vratio_ceil_c;
            cfg_q   <= force_max ? 2'd0 : 2'd1;
            op_q    <= '0;
            pend_q  <= 1'b0;
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (!pend_q) begin
            pend_q <= 1'b1;
          end else if (fin) begin
            pend_q <= 1'b0;
            case (op_q)
              3'd0:    wy_q <= quot;
              3'd1:    wc_q <= quot;
              3'd2:    wa_q <= quot;
              3'd3:    qy_q <= quot;
              3'd4:    qc_q <= quot;
              default: qa_q <= quot;
            endcase
            if (op_q == 3'(LAST_OP)) state_q <= ST_CHK;
            else                     op_q    <= op_q + 1'b1;
          end
        end
        default: begin
          if (fits || cfg_q == 2'd0) begin
            done    <= 1'b1;
            cfg_sel <= cfg_q;
            parts_y <= part_pl[0];
            parts_c <= part_pl[1];
            err     <= !fits;
            state_q <= ST_IDLE;
          end else begin
            cfg_q   <= cfg_next;
            op_q    <= 3'd3;
            state_q <= ST_RUN;
          end
        end
      endcase
    end
  end

  assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/lb_cfg_search_chk.sv
module lb_cfg_search_chk #(
  parameter int PART_MAX = 64,
  parameter int PART_W   = $clog2(PART_MAX + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [1:0]        cfg_sel,
  input logic [PART_W-1:0] parts_y,
  input logic [PART_W-1:0] parts_c,
  input logic              err
);
  // done lasts exactly one cycle
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // done only ends a busy period
  assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_start_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(cfg_sel) && $stable(parts_y) && $stable(parts_c) && $stable(err)));

  assert_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (parts_y <= PART_W'(PART_MAX) && parts_c <= PART_W'(PART_MAX)));

  assert_err_cfg0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (cfg_sel == 2'd0));
endmodule

bind lb_cfg_search lb_cfg_search_chk #(.PART_MAX(PART_MAX), .PART_W(PART_W)) u_chk (.*);

// File: tb/sim_lb_cfg_search.sv
module sim_lb_cfg_search;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, force_max = 1'b0, alpha_en = 1'b0, fmt_420 = 1'b0;
  logic [11:0] luma_vp_w = '0, chroma_vp_w = '0, out_w = '0;
  logic [1:0] depth_code = '0;
  logic [3:0] vtaps_y = '0, vtaps_c = '0, vratio_ceil_y = '0, vratio_ceil_c = '0;
  logic busy, done, err;
  logic [1:0] cfg_sel;
  logic [6:0] parts_y, parts_c;

  always #2 clk = ~clk;

  lb_cfg_search u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .force_max(force_max),
    .luma_vp_w(luma_vp_w), .chroma_vp_w(chroma_vp_w), .out_w(out_w),
    .depth_code(depth_code), .alpha_en(alpha_en), .fmt_420(fmt_420),
    .vtaps_y(vtaps_y), .vtaps_c(vtaps_c),
    .vratio_ceil_y(vratio_ceil_y), .vratio_ceil_c(vratio_ceil_c),
    .busy(busy), .done(done), .cfg_sel(cfg_sel),
    .parts_y(parts_y), .parts_c(parts_c), .err(err)
  );

  int n_cmp = 0, n_bad = 0, cycles = 0;
  string cur_tag = "R9", exp_tag = "R9";

  // reference model state
  bit m_busy = 0, m_done = 0;
  int m_left = 0;
  int e_cfg = 0, e_py = 0, e_pc = 0, e_err = 0;
  int p_cfg, p_py, p_pc, p_err;

  function automatic bit plane_ok(int cr, int p, int vt);
    if (cr > 2) return vt <= p - cr + 2;
    return vt <= p;
  endfunction

  task automatic ref_eval(output int cfg, output int py, output int pc,
                          output int er, output int k);
    int bpc, ly, lc, wy, wc, wa, my, mc, ma, pa, n;
    int order[4];
    bit ok;
    bpc = (depth_code == 0) ? 10 : (depth_code == 1) ? 8 : (depth_code == 2) ? 6 : 12;
    ly = (luma_vp_w < out_w) ? int'(luma_vp_w) : int'(out_w);
    lc = (chroma_vp_w < out_w) ? int'(chroma_vp_w) : int'(out_w);
    if (ly == 0) ly = 1;
    if (lc == 0) lc = 1;
    wy = (ly * bpc + 71) / 72;
    wc = (lc * bpc + 71) / 72;
    wa = (ly + 5) / 6;
    n = 0;
    if (force_max) begin order[0] = 0; n = 1; end
    else begin
      order[n++] = 1; order[n++] = 2;
      if (fmt_420) order[n++] = 3;
      order[n++] = 0;
    end
    k = 0; cfg = 0; py = 0; pc = 0; er = 0;
    for (int i = 0; i < n; i++) begin
      case (order[i])
        1: begin my = 816;  mc = 816;  ma = 984;  end
        2: begin my = 1088; mc = 1088; ma = 1312; end
        3: begin my = 4448; mc = 1904; ma = 2752; end
        default: begin my = 2752; mc = 2752; ma = 2752; end
      endcase
      py = my / wy; pc = mc / wc; pa = ma / wa;
      if (alpha_en && pa < py) py = pa;
      if (py > 64) py = 64;
      if (pc > 64) pc = 64;
      ok = plane_ok(int'(vratio_ceil_y), py, int'(vtaps_y)) &&
           plane_ok(int'(vratio_ceil_c), pc, int'(vtaps_c));
      k++;
      cfg = order[i];
      if (ok || order[i] == 0) begin er = ok ? 0 : 1; break; end
    end
  endtask

  always @(posedge clk) begin
    int kk;
    cycles++;
    if (!rst_n) begin
      m_busy = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0; m_done = 1;
          e_cfg = p_cfg; e_py = p_py; e_pc = p_pc; e_err = p_err;
        end
      end else if (start) begin
        ref_eval(p_cfg, p_py, p_pc, p_err, kk);
        exp_tag = cur_tag;
        m_busy = 1;
        m_left = 55 * (kk + 1) - 1;  // R8 latency
      end
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9", "busy", int'(busy), int'(m_busy));
      chk("R8", "done", int'(done), int'(m_done));
      if (m_done) begin
        chk(exp_tag, "cfg_sel", int'(cfg_sel), e_cfg);
        chk(exp_tag, "parts_y", int'(parts_y), e_py);
        chk(exp_tag, "parts_c", int'(parts_c), e_pc);
        chk(exp_tag, "err", int'(err), e_err);
      end
    end
  end

  task automatic run_case(string tag, int vy, int vc, int ow, int code, bit a,
                          bit f4, int vty, int vtc, int cry, int crc, bit fm, bit poke);
    int t;
    @(negedge clk);
    cur_tag = tag;
    luma_vp_w = 12'(vy); chroma_vp_w = 12'(vc); out_w = 12'(ow);
    depth_code = 2'(code); alpha_en = a; fmt_420 = f4; force_max = fm;
    vtaps_y = 4'(vty); vtaps_c = 4'(vtc);
    vratio_ceil_y = 4'(cry); vratio_ceil_c = 4'(crc);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R9: start with other inputs during the search must be ignored
      repeat (20) @(negedge clk);
      luma_vp_w = 12'd7; out_w = 12'd7; force_max = 1'b1; vtaps_y = 4'd1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (m_busy && t < 2000) begin @(negedge clk); t++; end
    if (t >= 2000) begin
      n_bad++;
      $display("FAIL %s search timeout: actual busy expected done", tag);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "reset busy", int'(busy), 0);
    chk("R9", "reset done", int'(done), 0);
    chk("R9", "reset cfg_sel", int'(cfg_sel), 0);
    chk("R9", "reset parts_y", int'(parts_y), 0);
    chk("R9", "reset parts_c", int'(parts_c), 0);
    chk("R9", "reset err", int'(err), 0);
    rst_n = 1'b1;
    run_case("R1", 640, 320, 640, 1, 0, 0, 4, 4, 1, 1, 0, 0);
    run_case("R1", 4000, 900, 1000, 0, 0, 0, 2, 2, 1, 1, 0, 0);
    run_case("R5", 1920, 960, 1920, 1, 0, 0, 4, 4, 1, 1, 0, 0);
    run_case("R5", 3840, 1920, 3840, 0, 0, 1, 6, 6, 2, 2, 0, 0);
    run_case("R2", 3840, 1920, 3840, 0, 0, 0, 6, 6, 2, 2, 0, 0);
    run_case("R2", 3840, 3840, 3840, 3, 0, 1, 8, 4, 1, 1, 0, 0);
    run_case("R3", 2400, 1200, 2400, 2, 1, 0, 6, 4, 1, 1, 0, 0);
    run_case("R3", 100, 50, 100, 1, 1, 0, 2, 2, 1, 1, 0, 0);
    run_case("R4", 1280, 640, 1280, 1, 0, 0, 6, 6, 4, 4, 0, 0);
    run_case("R4", 1280, 640, 1280, 1, 0, 0, 6, 6, 2, 2, 0, 0);
    run_case("R7", 4095, 4095, 4095, 3, 1, 0, 15, 15, 8, 8, 0, 0);
    run_case("R6", 640, 320, 640, 1, 0, 1, 4, 4, 1, 1, 1, 0);
    run_case("R6", 4095, 4095, 4095, 3, 0, 0, 15, 15, 9, 9, 1, 0);
    run_case("R1", 0, 0, 0, 3, 1, 0, 8, 8, 1, 1, 0, 0);
    run_case("R9", 1920, 960, 1920, 0, 0, 1, 5, 5, 3, 3, 0, 1);
    run_case("R5", 2560, 1280, 2560, 0, 0, 1, 4, 4, 1, 1, 0, 0);
    repeat (4) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule